// File: doc/BRIEF.md
# AXI4 Long-Burst Address Splitter

This block sits on one AXI4 read or write address channel, between an upstream manager and a downstream port that takes at most 16 beats per burst. It accepts one request at a time over a valid/ready handshake. An incrementing (INCR) request longer than the downstream limit goes out as a run of shorter sub-bursts. Every other request goes out once, exactly as it came in.

Only the address and the length may differ between a sub-burst and the request it came from. This holds even when the cache attribute marks the request as non-modifiable. Protection, lock, region, size, burst type, ID, QoS, cache and user bits are copied bit for bit to every sub-burst. FIXED and WRAP requests are never converted to another burst type.

When the last sub-burst of a request is taken downstream, the block does two things in that cycle. It completes the upstream handshake, and it reports the number of sub-bursts it issued on a separate valid signal. A data-merging unit elsewhere uses that count.

The control state machine has two states:
- `ST_IDLE`: no request is held, and the downstream valid is low. It goes to `ST_ISSUE` on a capture (upstream valid seen).
- `ST_ISSUE`: a sub-burst is presented downstream. On an accepted sub-burst that is not the last, it stays in `ST_ISSUE` (advance). On an accepted last sub-burst, it returns to `ST_IDLE` (complete).

Top module: `burst_splitter`

## Requirements
- R1: After reset, `dn_valid`, `up_ready` and `cnt_valid` are low, and stay low while no request is offered.
- R2: An INCR request (`up_burst` = 2'b01) with `up_len` 0..15 leaves as one sub-burst with all fields identical to the input, and its reported count is 1.
- R3: An INCR request with `up_len` above 15 leaves as ceil((`up_len`+1)/16) sub-bursts. Every sub-burst but the last has `dn_len` = 15. The last has `dn_len` = `up_len` mod 16.
- R4: The first sub-burst address equals `up_addr`. Each later sub-burst address is the previous one plus 16 × 2^`up_size`.
- R5: On every sub-burst, ID, size, burst, lock, cache, protection, QoS, region and user equal the input. This holds whatever the value of cache bit 1 (0 = non-modifiable).
- R6: FIXED (2'b00) and WRAP (2'b10) requests leave as one sub-burst with every field, length included, unchanged, and a count of 1.
- R7: `up_ready` is high only in the cycle in which the last sub-burst is accepted (`dn_valid` and `dn_ready` both high).
- R8: While `dn_valid` is high and `dn_ready` is low, every downstream field holds its value into the next cycle.
- R9: `cnt_valid` is high exactly in the cycle `up_ready` is high. `cnt_value` then equals the number of sub-bursts issued for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_id | input | ID_W | Transaction ID |
| up_addr | input | ADDR_W | Start address |
| up_len | input | 8 | Beats minus one |
| up_size | input | 3 | Log2 of bytes per beat |
| up_burst | input | 2 | Burst type: 00 FIXED, 01 INCR, 10 WRAP |
| up_lock | input | 1 | Exclusive access flag |
| up_cache | input | 4 | Cache attributes; bit 1 = modifiable |
| up_prot | input | 3 | Protection attributes |
| up_qos | input | 4 | Quality-of-service value |
| up_region | input | 4 | Region identifier |
| up_user | input | USER_W | User sideband |
| dn_valid | output | 1 | Sub-burst valid |
| dn_ready | input | 1 | Sub-burst accepted downstream |
| dn_id | output | ID_W | Transaction ID |
| dn_addr | output | ADDR_W | Sub-burst address |
| dn_len | output | 8 | Sub-burst beats minus one |
| dn_size | output | 3 | Copied size |
| dn_burst | output | 2 | Copied burst type |
| dn_lock | output | 1 | Copied lock |
| dn_cache | output | 4 | Copied cache attributes |
| dn_prot | output | 3 | Copied protection |
| dn_qos | output | 4 | Copied QoS |
| dn_region | output | 4 | Copied region |
| dn_user | output | USER_W | Copied user sideband |
| cnt_valid | output | 1 | Sub-burst count valid |
| cnt_value | output | 5 | Number of sub-bursts issued |

## Verification
Every INCR length from 0 to 255 is run at four beat sizes with the downstream always ready. This separates the single-transfer case, the exact multiples of 16, and the one-beat remainders that each add a sub-burst, and it shows the address stride scaling with size. A short set of boundary lengths is repeated against a stalling downstream, which tells correct holding of fields and late `up_ready` apart from a design that advances on its own. FIXED and WRAP requests with long lengths show that only INCR is split, and alternating cache bit 1 shows that modifiability changes nothing.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    // Burst type encodings used on the address channel
    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] BURST_WRAP  = 2'b10;

    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } split_state_e;

endpackage

// File: rtl/bsplit_fsm.sv
module bsplit_fsm
    import bsplit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic dn_ready,
    input  logic is_last,
    output logic load,
    output logic advance,
    output logic dn_valid,
    output logic up_ready
);

    split_state_e state_q;
    split_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        advance  = 1'b0;
        dn_valid = 1'b0;
        up_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (up_valid) begin
                    load    = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                dn_valid = 1'b1;
                if (dn_ready) begin
                    if (is_last) begin
                        up_ready = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bsplit_cursor.sv
module bsplit_cursor
    import bsplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ATTR_W    = 8,
    parameter int SUB_BEATS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [1:0]        in_burst,
    input  logic [ATTR_W-1:0] in_attr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic [SIZE_W-1:0] out_size,
    output logic [1:0]        out_burst,
    output logic [ATTR_W-1:0] out_attr,
    output logic [LEN_W-1:0]  orig_len,
    output logic              is_last
);

    localparam logic [LEN_W-1:0]  CHUNK_LEN  = LEN_W'(SUB_BEATS - 1);
    localparam logic [LEN_W-1:0]  CHUNK_STEP = LEN_W'(SUB_BEATS);
    localparam logic [ADDR_W-1:0] BEAT_UNIT  = ADDR_W'(SUB_BEATS);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_q;
    logic [SIZE_W-1:0] size_q;
    logic [1:0]        burst_q;
    logic [ATTR_W-1:0] attr_q;
    logic [ADDR_W-1:0] stride;
    logic              incr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            len_q   <= '0;
            size_q  <= '0;
            burst_q <= '0;
            attr_q  <= '0;
        end else if (load) begin
            addr_q  <= in_addr;
            rem_q   <= in_len;
            len_q   <= in_len;
            size_q  <= in_size;
            burst_q <= in_burst;
            attr_q  <= in_attr;
        end else if (advance) begin
            addr_q <= addr_q + stride;
            rem_q  <= rem_q - CHUNK_STEP;
        end
    end

    always_comb begin
        stride   = BEAT_UNIT << size_q;
        incr     = (burst_q == BURST_INCR);
        is_last  = !incr || (rem_q <= CHUNK_LEN);
        out_len  = is_last ? rem_q : CHUNK_LEN;
    end

    assign out_addr  = addr_q;
    assign out_size  = size_q;
    assign out_burst = burst_q;
    assign out_attr  = attr_q;
    assign orig_len  = len_q;

endmodule

// File: rtl/bsplit_count.sv
module bsplit_count
    import bsplit_pkg::*;
#(
    parameter int SUB_BEATS = 16,
    parameter int CNT_W     = 5
) (
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       burst,
    output logic [CNT_W-1:0] count
);

    localparam int SHIFT = $clog2(SUB_BEATS);

    logic [CNT_W-1:0] chunks;

    assign chunks = CNT_W'(len >> SHIFT) + CNT_W'(1);
    assign count  = (burst == BURST_INCR) ? chunks : CNT_W'(1);

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import bsplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 4,
    parameter int USER_W    = 2,
    parameter int SUB_BEATS = 16,
    parameter int CNT_W     = LEN_W - $clog2(SUB_BEATS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ID_W-1:0]   up_id,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [7:0]        up_len,
    input  logic [2:0]        up_size,
    input  logic [1:0]        up_burst,
    input  logic              up_lock,
    input  logic [3:0]        up_cache,
    input  logic [2:0]        up_prot,
    input  logic [3:0]        up_qos,
    input  logic [3:0]        up_region,
    input  logic [USER_W-1:0] up_user,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ID_W-1:0]   dn_id,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [7:0]        dn_len,
    output logic [2:0]        dn_size,
    output logic [1:0]        dn_burst,
    output logic              dn_lock,
    output logic [3:0]        dn_cache,
    output logic [2:0]        dn_prot,
    output logic [3:0]        dn_qos,
    output logic [3:0]        dn_region,
    output logic [USER_W-1:0] dn_user,
    output logic              cnt_valid,
    output logic [CNT_W-1:0]  cnt_value
);

    // passthrough attributes: id, user, lock, cache, prot, qos, region
    localparam int ATTR_W = ID_W + USER_W + 1 + 4 + 3 + 4 + 4;

    logic              load;
    logic              advance;
    logic              is_last;
    logic [ATTR_W-1:0] in_attr;
    logic [ATTR_W-1:0] out_attr;
    logic [LEN_W-1:0]  orig_len;

    assign in_attr = {up_id, up_user, up_lock, up_cache, up_prot, up_qos, up_region};
    assign {dn_id, dn_user, dn_lock, dn_cache, dn_prot, dn_qos, dn_region} = out_attr;

    bsplit_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .dn_ready (dn_ready),
        .is_last  (is_last),
        .load     (load),
        .advance  (advance),
        .dn_valid (dn_valid),
        .up_ready (up_ready)
    );

    bsplit_cursor #(
        .ADDR_W    (ADDR_W),
        .ATTR_W    (ATTR_W),
        .SUB_BEATS (SUB_BEATS)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .in_addr   (up_addr),
        .in_len    (up_len),
        .in_size   (up_size),
        .in_burst  (up_burst),
        .in_attr   (in_attr),
        .out_addr  (dn_addr),
        .out_len   (dn_len),
        .out_size  (dn_size),
        .out_burst (dn_burst),
        .out_attr  (out_attr),
        .orig_len  (orig_len),
        .is_last   (is_last)
    );

    bsplit_count #(
        .SUB_BEATS (SUB_BEATS),
        .CNT_W     (CNT_W)
    ) u_count (
        .len   (orig_len),
        .burst (dn_burst),
        .count (cnt_value)
    );

    // count is reported alongside completion of the upstream handshake
    assign cnt_valid = up_ready;

endmodule

// File: rtl/bsplit_checker.sv
module bsplit_checker #(
    parameter int ADDR_W    = 32,
    parameter int SUB_BEATS = 16,
    parameter int CNT_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [7:0]        dn_len,
    input logic [2:0]        dn_size,
    input logic [1:0]        dn_burst,
    input logic              dn_lock,
    input logic [3:0]        dn_cache,
    input logic [2:0]        dn_prot,
    input logic [3:0]        dn_region,
    input logic              cnt_valid,
    input logic [CNT_W-1:0]  cnt_value
);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_len)
                                     && $stable(dn_size) && $stable(dn_burst)));

    p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_burst == 2'b01) |-> (dn_len <= 8'(SUB_BEATS - 1)));

    p_ready_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (up_valid && dn_valid && dn_ready));

    p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> (up_ready && cnt_value != '0));

    p_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && !up_ready) |=>
            (dn_valid && dn_addr == $past(dn_addr) + (ADDR_W'(SUB_BEATS) << $past(dn_size))));

    p_attr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && !up_ready) |=>
            ($stable(dn_prot) && $stable(dn_lock) && $stable(dn_cache)
             && $stable(dn_region) && $stable(dn_size) && $stable(dn_burst)));

endmodule

bind burst_splitter bsplit_checker #(
    .ADDR_W    (ADDR_W),
    .SUB_BEATS (SUB_BEATS),
    .CNT_W     (CNT_W)
) u_bsplit_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_addr   (dn_addr),
    .dn_len    (dn_len),
    .dn_size   (dn_size),
    .dn_burst  (dn_burst),
    .dn_lock   (dn_lock),
    .dn_cache  (dn_cache),
    .dn_prot   (dn_prot),
    .dn_region (dn_region),
    .cnt_valid (cnt_valid),
    .cnt_value (cnt_value)
);

// File: tb/tb_burst_splitter.sv
`timescale 1ns/1ps
module tb_burst_splitter;

    localparam int ADDR_W = 32;
    localparam int ID_W   = 4;
    localparam int USER_W = 2;
    localparam int CNT_W  = 5;
    localparam int AT_W   = ID_W + USER_W + 1 + 4 + 3 + 4 + 4 + 3 + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0, up_ready;
    logic [ID_W-1:0]   up_id = '0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [7:0]        up_len = '0;
    logic [2:0]        up_size = '0;
    logic [1:0]        up_burst = '0;
    logic              up_lock = 1'b0;
    logic [3:0]        up_cache = '0, up_qos = '0, up_region = '0;
    logic [2:0]        up_prot = '0;
    logic [USER_W-1:0] up_user = '0;
    logic dn_valid, dn_ready = 1'b0;
    logic [ID_W-1:0]   dn_id;
    logic [ADDR_W-1:0] dn_addr;
    logic [7:0]        dn_len;
    logic [2:0]        dn_size;
    logic [1:0]        dn_burst;
    logic              dn_lock;
    logic [3:0]        dn_cache, dn_qos, dn_region;
    logic [2:0]        dn_prot;
    logic [USER_W-1:0] dn_user;
    logic              cnt_valid;
    logic [CNT_W-1:0]  cnt_value;

    int errors = 0;
    int checks = 0;
    int pat = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    burst_splitter dut (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_id(up_id), .up_addr(up_addr),
        .up_len(up_len), .up_size(up_size), .up_burst(up_burst), .up_lock(up_lock),
        .up_cache(up_cache), .up_prot(up_prot), .up_qos(up_qos), .up_region(up_region),
        .up_user(up_user),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_id(dn_id), .dn_addr(dn_addr),
        .dn_len(dn_len), .dn_size(dn_size), .dn_burst(dn_burst), .dn_lock(dn_lock),
        .dn_cache(dn_cache), .dn_prot(dn_prot), .dn_qos(dn_qos), .dn_region(dn_region),
        .dn_user(dn_user),
        .cnt_valid(cnt_valid), .cnt_value(cnt_value)
    );

    function automatic logic [AT_W-1:0] dn_attr();
        return {dn_id, dn_user, dn_lock, dn_cache, dn_prot, dn_qos, dn_region, dn_size, dn_burst};
    endfunction

    function automatic logic [AT_W-1:0] up_attr();
        return {up_id, up_user, up_lock, up_cache, up_prot, up_qos, up_region, up_size, up_burst};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // drive one request and follow it until the upstream handshake completes
    task automatic run_req(input int len, input int size, input int burst, input bit bp);
        int n;
        int k = 0;
        int guard = 0;
        bit held = 0;
        bit done;
        logic [ADDR_W-1:0] s_addr;
        logic [7:0] s_len;
        logic [AT_W-1:0] s_attr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] exp_addr;
        logic [7:0] exp_len;
        string ltag;

        base      = 32'h4000_0000 + ADDR_W'(len * 64) + ADDR_W'(size * 4);
        up_addr   = base;
        up_len    = 8'(len);
        up_size   = 3'(size);
        up_burst  = 2'(burst);
        up_id     = 4'(len + size);
        up_user   = 2'(len);
        up_lock   = len[1];
        up_cache  = {len[3], len[2], len[0], 1'b1};   // bit 1 alternates with len
        up_prot   = 3'(len + 3);
        up_qos    = 4'(len >> 2);
        up_region = 4'(len ^ size);
        up_valid  = 1'b1;
        n = (burst == 1) ? (len >> 4) + 1 : 1;
        ltag = (burst != 1) ? "R6" : ((n == 1) ? "R2" : "R3");

        while (1) begin
            dn_ready = bp ? ((pat % 3) != 0) : 1'b1;
            pat++;
            #1;
            if (held) begin
                check(dn_valid && dn_addr == s_addr && dn_len == s_len && dn_attr() == s_attr,
                      "R8 hold", {dn_addr, dn_len}, {s_addr, s_len});
            end
            done = dn_valid && dn_ready && (k == n - 1);
            check(up_ready == done, "R7 up_ready", up_ready, done);
            check(cnt_valid == done, "R9 cnt_valid", cnt_valid, done);
            if (dn_valid && dn_ready) begin
                exp_addr = base + ADDR_W'(k) * (ADDR_W'(16) << size);
                exp_len  = (burst != 1) ? 8'(len) : ((k == n - 1) ? 8'(len & 15) : 8'd15);
                check(dn_addr == exp_addr, "R4 addr", dn_addr, exp_addr);
                check(dn_len == exp_len, ltag, dn_len, exp_len);
                check(dn_attr() == up_attr(), "R5 attrs", dn_attr(), up_attr());
                if (done)
                    check(cnt_value == CNT_W'(n), "R9 count", cnt_value, n);
                k++;
            end
            held = dn_valid && !dn_ready;
            s_addr = dn_addr;
            s_len  = dn_len;
            s_attr = dn_attr();
            @(negedge clk);
            if (done) break;
            guard++;
            if (guard > 200) begin
                check(1'b0, "R7 hang", guard, n);
                break;
            end
        end
        up_valid = 1'b0;
        dn_ready = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "watchdog", cycles, 150000);
                finish_run();
            end
        end
    end

    initial begin
        int lens_bp[8] = '{0, 15, 16, 17, 31, 32, 200, 255};
        repeat (3) @(negedge clk);
        #1;
        check(!dn_valid && !up_ready && !cnt_valid, "R1 in reset",
              {dn_valid, up_ready, cnt_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!dn_valid && !up_ready && !cnt_valid, "R1 idle after reset",
              {dn_valid, up_ready, cnt_valid}, 0);
        @(negedge clk);

        // full INCR length sweep at four beat sizes
        for (int s = 0; s < 4; s++)
            for (int l = 0; l < 256; l++)
                run_req(l, s, 1, 1'b0);

        // boundary lengths against a stalling downstream
        for (int i = 0; i < 8; i++) begin
            run_req(lens_bp[i], 2, 1, 1'b1);
            run_req(lens_bp[i], 5, 1, 1'b1);
        end

        // FIXED and WRAP requests stay whole
        for (int l = 0; l < 256; l += 17) begin
            run_req(l, 1, 0, 1'b0);
            run_req(l, 3, 0, 1'b1);
        end
        run_req(1, 2, 2, 1'b0);
        run_req(3, 2, 2, 1'b1);
        run_req(7, 0, 2, 1'b0);
        run_req(15, 3, 2, 1'b1);

        repeat (2) @(negedge clk);
        #1;
        check(!dn_valid && !up_ready && !cnt_valid, "R1 idle at end",
              {dn_valid, up_ready, cnt_valid}, 0);
        finish_run();
    end

endmodule